// File: doc/BRIEF.md
# Single-Wire Bus Timeslot Master

This block is the bit-level engine for an open-drain single-wire bus. A host issues one command at a time: a bus reset with device-presence detection, a write of one or more bytes, or a read of one or more bytes. The engine turns each command into timed low pulses on the bus. A clock-enable strobe that fires once per microsecond paces every interval.

The host presents a command code, a byte count, a pull-up request flag and a transmit byte. The engine takes the transmit byte when it starts each byte and pulses `tx_take` so the host can present the next one. For reads, each assembled byte appears on `rx_data` with a one-cycle `rx_valid`. At the end of a command, `done` pulses for one cycle. `present` and `short_fault` hold the outcome of the last reset until the next reset is accepted. The bus input passes through a two-flop synchronizer before any sampling.

The control state machine has these states:
- `ST_IDLE`: waits for a command.
- `ST_PRECHK`: checks the bus before a reset.
- `ST_RST`: the reset window.
- `ST_SETTLE`: the post-reset wait.
- `ST_SLOT`: the bit timeslots.
- `ST_FINISH`: the one-cycle completion state.

The transitions are:
- `ST_IDLE` to `ST_PRECHK` on an accepted reset.
- `ST_IDLE` to `ST_SLOT` on an accepted write or read with a nonzero count.
- `ST_IDLE` to `ST_FINISH` on a write or read with a zero count.
- `ST_PRECHK` to `ST_FINISH` when the bus is already low.
- `ST_PRECHK` to `ST_RST` otherwise.
- `ST_RST` to `ST_SETTLE` after 1030 ticks.
- `ST_SETTLE` to `ST_FINISH` after 500 ticks.
- `ST_SLOT` to `ST_FINISH` after the recovery time of the last bit of the last byte.
- `ST_FINISH` to `ST_IDLE` always.

Top module: `owm_slot_master`

## Requirements
- R1: A reset command (`cmd_op` = 2'b01) drives the bus low for 480 ticks and samples presence at tick 550. It then waits until tick 1030, waits a further 500 ticks and checks the bus. `present` becomes 1 only if the bus was low at tick 550 and is high at that final check. `done` follows about 1530 ticks after the command.
- R2: If the synchronized bus is low when a reset is accepted, the engine does not drive the bus at all. It finishes within a few cycles with `present` = 0 and `short_fault` = 1.
- R3: If the bus is still low at the end of the 500-tick post-reset wait, the engine sets `short_fault` = 1 and `present` = 0. `short_fault` is never 1 together with `present`.
- R4: A write command (`cmd_op` = 2'b10) sends each bit in a 70-tick slot. A 0 bit drives the bus low for 60 ticks; a 1 bit drives it low for 6 ticks. The bus is always released for at least the last 10 ticks of each slot.
- R5: Bytes are sent least significant bit first, and `cmd_len` bytes are sent in total. `tx_byte` is taken at the start of each byte, and `tx_take` pulses once per byte taken.
- R6: A read command (`cmd_op` = 2'b11) drives each 70-tick slot low for 6 ticks and samples the bus at tick 15. Sampled bits fill a cleared byte, least significant bit first. Each complete byte appears on `rx_data` with a one-cycle `rx_valid`.
- R7: `busy` is high from the cycle after a command is accepted until the engine returns to idle. While busy, any command is ignored with no effect on the bus or on the flags. `cmd_op` = 2'b00 is never accepted.
- R8: `done` is a one-cycle pulse at the end of every accepted command.
- R9: A write with `cmd_pullup` = 1 asserts `pullup_en` only after the last slot's recovery time has ended. The output then stays high until the next command is accepted. `pullup_en` is never high while the bus is driven, and a write without the request leaves it low.
- R10: A write or read with `cmd_len` = 0 produces no bus activity and pulses `done` within a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle strobe, once per microsecond |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 none, 01 reset, 10 write, 11 read |
| cmd_len | input | LEN_W | Byte count for write and read |
| cmd_pullup | input | 1 | Request strong pull-up after a write |
| tx_byte | input | DATA_W | Byte to transmit, taken at each byte start |
| tx_take | output | 1 | Pulse: `tx_byte` was taken |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | Pulse: `rx_data` updated |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| present | output | 1 | Device detected by last reset |
| short_fault | output | 1 | Bus found stuck low by last reset |
| bus_drive_low | output | 1 | Open-drain enable; 1 pulls the bus low |
| bus_in | input | 1 | Raw bus level |
| pullup_en | output | 1 | Strong pull-up enable |

## Verification
A wrong tick counter or a wrong slot-width choice shows up within one slot as a low pulse of the wrong length, measured directly on `bus_drive_low`. A wrong bit index or a wrong byte count shows up at the end of the command: decoded write bytes do not match, `rx_data` is wrong, or the number of `tx_take` pulses is off.

Faults in the reset path appear only at `done`, about 1530 ticks after the command, as a wrong `present`/`short_fault` pair. An engine that fails to ignore commands while busy shows up at the ports: a stray reset pulse appears, or the reset flags change.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_RESET = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } owm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECHK,
        ST_RST,
        ST_SETTLE,
        ST_SLOT,
        ST_FINISH
    } owm_state_e;

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/owm_bytebuf.sv
module owm_bytebuf #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  logic              clr,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              set_bit,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_acc
);
    logic [DATA_W-1:0] tx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr  <= '0;
            rx_acc <= '0;
        end else begin
            if (load)       tx_sr <= load_val;
            else if (shift) tx_sr <= tx_sr >> 1;
            // bits are OR-ed in, so the byte is cleared at every start
            if (clr)         rx_acc <= '0;
            else if (set_en) rx_acc[set_idx] <= rx_acc[set_idx] | set_bit;
        end
    end

    assign tx_bit = tx_sr[0];
endmodule

// File: rtl/owm_slot_master.sv
module owm_slot_master
    import owm_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 8,
    parameter int RST_LOW_T  = 480,
    parameter int RST_SAMP_T = 550,
    parameter int RST_SPAN_T = 1030,
    parameter int SETTLE_T   = 500,
    parameter int SLOT_T     = 70,
    parameter int ZERO_LOW_T = 60,
    parameter int ONE_LOW_T  = 6,
    parameter int SAMP_T     = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_pullup,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_take,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy,
    output logic              done,
    output logic              present,
    output logic              short_fault,
    output logic              bus_drive_low,
    input  logic              bus_in,
    output logic              pullup_en
);
    localparam int CNT_W = $clog2(RST_SPAN_T + SETTLE_T + SLOT_T + 1);
    localparam int IDX_W = $clog2(DATA_W);

    owm_state_e         st, st_nx;
    owm_op_e            op_in, op_q;
    logic [CNT_W-1:0]   tcnt;
    logic [IDX_W-1:0]   bit_idx;
    logic [LEN_W-1:0]   left;
    logic               pull_req, pres_smp, bus_s;
    logic               accept, slot_end, byte_end, last_byte;
    logic               tx_bit, buf_load, buf_shift, buf_clr, buf_set;
    logic [DATA_W-1:0]  rx_acc;
    logic [CNT_W-1:0]   low_len;

    owm_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s)
    );

    assign op_in     = owm_op_e'(cmd_op);
    assign accept    = (st == ST_IDLE) && cmd_valid && (op_in != OP_NONE);
    assign slot_end  = (st == ST_SLOT) && tick_en && (tcnt == CNT_W'(SLOT_T - 1));
    assign byte_end  = slot_end && (bit_idx == IDX_W'(DATA_W - 1));
    assign last_byte = (left == LEN_W'(1));

    assign buf_load  = (accept && op_in == OP_WRITE) ||
                       (byte_end && !last_byte && op_q == OP_WRITE);
    assign buf_shift = slot_end && !byte_end;
    assign buf_clr   = accept || byte_end;
    assign buf_set   = (st == ST_SLOT) && (op_q == OP_READ) && tick_en &&
                       (tcnt == CNT_W'(SAMP_T - 1));

    owm_bytebuf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .load(buf_load), .load_val(tx_byte), .shift(buf_shift),
        .clr(buf_clr), .set_en(buf_set), .set_idx(bit_idx), .set_bit(bus_s),
        .tx_bit(tx_bit), .rx_acc(rx_acc)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (accept) begin
                if (op_in == OP_RESET)      st_nx = ST_PRECHK;
                else if (cmd_len == '0)     st_nx = ST_FINISH;
                else                        st_nx = ST_SLOT;
            end
            ST_PRECHK: st_nx = bus_s ? ST_RST : ST_FINISH;
            ST_RST:    if (tick_en && tcnt == CNT_W'(RST_SPAN_T - 1)) st_nx = ST_SETTLE;
            ST_SETTLE: if (tick_en && tcnt == CNT_W'(SETTLE_T - 1))   st_nx = ST_FINISH;
            ST_SLOT:   if (byte_end && last_byte)                      st_nx = ST_FINISH;
            ST_FINISH: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // state register and sequencing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            op_q        <= OP_NONE;
            tcnt        <= '0;
            bit_idx     <= '0;
            left        <= '0;
            pull_req    <= 1'b0;
            pres_smp    <= 1'b0;
            present     <= 1'b0;
            short_fault <= 1'b0;
            pullup_en   <= 1'b0;
            tx_take     <= 1'b0;
            rx_valid    <= 1'b0;
            rx_data     <= '0;
        end else begin
            st       <= st_nx;
            tx_take  <= 1'b0;
            rx_valid <= 1'b0;
            if (accept) begin
                op_q      <= op_in;
                pull_req  <= cmd_pullup && (op_in == OP_WRITE);
                pullup_en <= 1'b0;
                tcnt      <= '0;
                bit_idx   <= '0;
                left      <= cmd_len;
                if (op_in == OP_RESET) begin
                    present     <= 1'b0;
                    short_fault <= 1'b0;
                end
                if (op_in == OP_WRITE && cmd_len != '0) tx_take <= 1'b1;
            end else begin
                unique case (st)
                    ST_PRECHK: if (!bus_s) short_fault <= 1'b1;
                    ST_RST: if (tick_en) begin
                        if (tcnt == CNT_W'(RST_SAMP_T - 1)) pres_smp <= !bus_s;
                        tcnt <= (tcnt == CNT_W'(RST_SPAN_T - 1)) ? '0 : tcnt + CNT_W'(1);
                    end
                    ST_SETTLE: if (tick_en) begin
                        tcnt <= tcnt + CNT_W'(1);
                        if (tcnt == CNT_W'(SETTLE_T - 1)) begin
                            present     <= pres_smp && bus_s;
                            short_fault <= !bus_s;
                        end
                    end
                    ST_SLOT: if (tick_en) begin
                        if (slot_end) begin
                            tcnt    <= '0;
                            bit_idx <= bit_idx + IDX_W'(1);
                            if (byte_end) begin
                                bit_idx <= '0;
                                left    <= left - LEN_W'(1);
                                if (op_q == OP_READ) begin
                                    rx_valid <= 1'b1;
                                    rx_data  <= rx_acc;
                                end
                                if (!last_byte && op_q == OP_WRITE) tx_take <= 1'b1;
                                if (last_byte && pull_req) pullup_en <= 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        low_len = (op_q == OP_READ || tx_bit) ? CNT_W'(ONE_LOW_T) : CNT_W'(ZERO_LOW_T);
        unique case (st)
            ST_RST:  bus_drive_low = (tcnt < CNT_W'(RST_LOW_T));
            ST_SLOT: bus_drive_low = (tcnt < low_len);
            default: bus_drive_low = 1'b0;
        endcase
        busy = (st != ST_IDLE);
        done = (st == ST_FINISH);
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_drive_low); // R7
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy); // R7
    AST_PULLUP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_en |-> !bus_drive_low); // R9
    AST_SLOT_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLOT && tcnt >= CNT_W'(SLOT_T - 10)) |-> !bus_drive_low); // R4
    AST_SLOT_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLOT) |-> (left != '0)); // R5
    AST_SHORT_NOT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        short_fault |-> !present); // R3
endmodule

// File: tb/owm_slot_master_tb.sv
module owm_slot_master_tb;
    localparam int DIV = 4;
    localparam logic [9:0] VEC [0:5] = '{10'h2A5, 10'h200, 10'h2FF,
                                         10'h33C, 10'h381, 10'h3C6};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_pullup = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_len = 8'd0;
    logic [7:0] tx_byte, rx_data;
    logic tx_take, rx_valid, busy, done, present, short_fault;
    logic bus_drive_low, bus_in, pullup_en, tick_en;
    logic slave_low = 1'b0, stuck_low = 1'b0, drv_q = 1'b0;

    int checks = 0, fails = 0, cyc = 0, tdiv = 0;
    int nfall = 0, fall_t = 0, wr_n = 0, rd_n = 0, tx_idx = 0, tx_base = 0;
    int dn = 0, sbit = 0, sbase = 0, smode = 0, delay_cnt = 0, hold_cnt = 0;
    int  wr_w     [0:1023];
    int  fall_gap [0:1023];
    logic wr_bits [0:1023];
    logic [7:0] rd_log [0:63];
    logic [7:0] tx_src [0:3];
    logic [7:0] sdata  [0:3];

    always #4 clk = ~clk;

    always @(posedge clk) tdiv <= (tdiv == DIV - 1) ? 0 : tdiv + 1;
    assign tick_en = (tdiv == DIV - 1);
    assign bus_in  = !(bus_drive_low || slave_low || stuck_low);
    assign tx_byte = tx_src[(tx_idx - tx_base) & 3];

    owm_slot_master u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_pullup(cmd_pullup),
        .tx_byte(tx_byte), .tx_take(tx_take), .rx_data(rx_data),
        .rx_valid(rx_valid), .busy(busy), .done(done), .present(present),
        .short_fault(short_fault), .bus_drive_low(bus_drive_low),
        .bus_in(bus_in), .pullup_en(pullup_en)
    );

    // bus monitor and slave model
    always @(posedge clk) begin
        cyc   <= cyc + 1;
        drv_q <= bus_drive_low;
        if (delay_cnt > 0) begin
            delay_cnt <= delay_cnt - 1;
            if (delay_cnt == 1) begin
                slave_low <= 1'b1;
                hold_cnt  <= (smode == 3) ? 1200 * DIV : 120 * DIV;
            end
        end else if (hold_cnt > 0) begin
            hold_cnt <= hold_cnt - 1;
            if (hold_cnt == 1) slave_low <= 1'b0;
        end
        if (bus_drive_low && !drv_q) begin
            if (nfall > 0) fall_gap[nfall & 1023] <= cyc - fall_t;
            fall_t <= cyc;
            nfall  <= nfall + 1;
        end
        if (!bus_drive_low && drv_q) begin
            wr_w[wr_n & 1023]    <= cyc - fall_t;
            wr_bits[wr_n & 1023] <= ((cyc - fall_t) < 30 * DIV);
            wr_n <= wr_n + 1;
            if (smode == 2) begin
                if (!sdata[((sbit - sbase) >> 3) & 3][(sbit - sbase) & 7]) begin
                    slave_low <= 1'b1;
                    hold_cnt  <= 20 * DIV;
                end
                sbit <= sbit + 1;
            end else if (smode == 1 || smode == 3) begin
                delay_cnt <= 30 * DIV;
            end
        end
        if (rx_valid) begin
            rd_log[rd_n & 63] <= rx_data;
            rd_n <= rd_n + 1;
        end
        if (tx_take) tx_idx <= tx_idx + 1;
        if (done) dn <= dn + 1;
    end

    task automatic chk(input string req, input string what, input int act,
                       input int exp, input bit ok);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ticks(input int clocks);
        return (clocks + DIV / 2) / DIV;
    endfunction

    function automatic logic [7:0] wr_byte(input int base);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[k] = wr_bits[(base + k) & 1023];
        return b;
    endfunction

    task automatic issue(input logic [1:0] op, input int len, input bit pu);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_len = 8'(len); cmd_pullup = pu;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00; cmd_len = 8'd0; cmd_pullup = 1'b0;
    endtask

    task automatic wait_done(output int t);
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int t, wb, fb, rb, d0, tk;
        for (int i = 0; i < 4; i++) begin tx_src[i] = 8'h00; sdata[i] = 8'hFF; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R7", "busy after reset", int'(busy), 0, busy == 1'b0);
        chk("R8", "done after reset", int'(done), 0, done == 1'b0);
        chk("R9", "drive/pullup after reset", int'({bus_drive_low, pullup_en}), 0,
            {bus_drive_low, pullup_en} == 2'b00);
        chk("R1", "flags after reset", int'({present, short_fault}), 0,
            {present, short_fault} == 2'b00);

        // vector table: single-byte writes and reads
        for (int i = 0; i < 6; i++) begin
            logic [1:0] vop;
            logic [7:0] vd;
            vop = VEC[i][9:8];
            vd  = VEC[i][7:0];
            wb = wr_n; fb = nfall; rb = rd_n;
            if (vop == 2'b10) begin
                tx_base = tx_idx; tx_src[0] = vd; smode = 0;
            end else begin
                sbase = sbit; sdata[0] = vd; smode = 2;
            end
            issue(vop, 1, 1'b0);
            chk("R7", "busy after accept", int'(busy), 1, busy == 1'b1);
            wait_done(t);
            repeat (3) @(negedge clk);
            smode = 0;
            tk = ticks(wr_w[(wb + 1) & 1023]);
            chk("R4", "slot period", ticks(fall_gap[(fb + 1) & 1023]), 70,
                ticks(fall_gap[(fb + 1) & 1023]) >= 69 && ticks(fall_gap[(fb + 1) & 1023]) <= 71);
            if (vop == 2'b10) begin
                chk("R5", "written byte LSB first", int'(wr_byte(wb)), int'(vd), wr_byte(wb) == vd);
                chk("R4", "bit1 low width", tk, vd[1] ? 6 : 60, (tk - (vd[1] ? 6 : 60)) inside {-1, 0, 1});
                chk("R9", "no pullup without request", int'(pullup_en), 0, pullup_en == 1'b0);
            end else begin
                chk("R6", "read byte", int'(rd_log[rb & 63]), int'(vd), rd_log[rb & 63] == vd && rd_n == rb + 1);
                chk("R6", "read slot low width", tk, 6, tk >= 5 && tk <= 8);
            end
        end

        // multi-byte write
        wb = wr_n; tx_base = tx_idx; d0 = tx_idx;
        tx_src[0] = 8'h12; tx_src[1] = 8'h34; tx_src[2] = 8'hC7;
        issue(2'b10, 3, 1'b0);
        wait_done(t);
        @(negedge clk);
        chk("R5", "byte 0", int'(wr_byte(wb)), 'h12, wr_byte(wb) == 8'h12);
        chk("R5", "byte 1", int'(wr_byte(wb + 8)), 'h34, wr_byte(wb + 8) == 8'h34);
        chk("R5", "byte 2", int'(wr_byte(wb + 16)), 'hC7, wr_byte(wb + 16) == 8'hC7);
        chk("R5", "tx_take count", tx_idx - d0, 3, tx_idx - d0 == 3);
        chk("R5", "bit count", wr_n - wb, 24, wr_n - wb == 24);

        // multi-byte read
        rb = rd_n; sbase = sbit; sdata[0] = 8'hE1; sdata[1] = 8'h5A; smode = 2;
        issue(2'b11, 2, 1'b0);
        wait_done(t);
        repeat (3) @(negedge clk);
        smode = 0;
        chk("R6", "read count", rd_n - rb, 2, rd_n - rb == 2);
        chk("R6", "read byte 0", int'(rd_log[rb & 63]), 'hE1, rd_log[rb & 63] == 8'hE1);
        chk("R6", "read byte 1", int'(rd_log[(rb + 1) & 63]), 'h5A, rd_log[(rb + 1) & 63] == 8'h5A);

        // reset with a device answering
        wb = wr_n; smode = 1;
        issue(2'b01, 0, 1'b0);
        wait_done(t);
        tk = ticks(t);
        chk("R1", "presence flags", int'({present, short_fault}), 2, {present, short_fault} == 2'b10);
        chk("R1", "reset duration ticks", tk, 1530, tk >= 1527 && tk <= 1533);
        chk("R1", "reset low width", ticks(wr_w[wb & 1023]), 480,
            ticks(wr_w[wb & 1023]) >= 478 && ticks(wr_w[wb & 1023]) <= 481);
        @(negedge clk);
        chk("R8", "done one cycle", int'(done), 0, done == 1'b0);
        smode = 0;
        wait (!slave_low);

        // reset with no device
        issue(2'b01, 0, 1'b0);
        wait_done(t);
        chk("R1", "no device flags", int'({present, short_fault}), 0, {present, short_fault} == 2'b00);

        // bus held low after the reset window
        smode = 3;
        issue(2'b01, 0, 1'b0);
        wait_done(t);
        chk("R3", "post-reset short", int'({present, short_fault}), 1, {present, short_fault} == 2'b01);
        smode = 0;
        wait (!slave_low);
        repeat (4) @(negedge clk);

        // bus already low before reset
        stuck_low = 1'b1;
        repeat (4) @(negedge clk);
        fb = nfall;
        issue(2'b01, 0, 1'b0);
        wait_done(t);
        chk("R2", "abort latency", t, 1, t <= 4);
        chk("R2", "abort flags", int'({present, short_fault}), 1, {present, short_fault} == 2'b01);
        chk("R2", "no drive on abort", nfall - fb, 0, nfall == fb);
        stuck_low = 1'b0;
        repeat (4) @(negedge clk);

        // command while busy is ignored
        wb = wr_n; d0 = dn; tx_base = tx_idx; tx_src[0] = 8'h55;
        issue(2'b10, 1, 1'b0);
        repeat (100 * DIV) @(negedge clk);
        chk("R7", "busy mid-write", int'(busy), 1, busy == 1'b1);
        issue(2'b01, 0, 1'b0);
        wait_done(t);
        @(negedge clk);
        chk("R7", "byte unaffected", int'(wr_byte(wb)), 'h55, wr_byte(wb) == 8'h55 && wr_n - wb == 8);
        chk("R7", "flags unaffected", int'(short_fault), 1, short_fault == 1'b1);
        chk("R8", "single done", dn - d0, 1, dn - d0 == 1);

        // strong pull-up after write
        tx_base = tx_idx; tx_src[0] = 8'h0F;
        issue(2'b10, 1, 1'b1);
        repeat (200 * DIV) @(negedge clk);
        chk("R9", "no pullup mid-write", int'(pullup_en), 0, pullup_en == 1'b0);
        wait_done(t);
        chk("R9", "pullup at done", int'(pullup_en), 1, pullup_en == 1'b1);
        repeat (50) @(negedge clk);
        chk("R9", "pullup held", int'(pullup_en), 1, pullup_en == 1'b1);

        // zero-length commands
        fb = nfall;
        issue(2'b10, 0, 1'b0);
        chk("R9", "pullup released on accept", int'(pullup_en), 0, pullup_en == 1'b0);
        wait_done(t);
        chk("R10", "zero-length write latency", t, 0, t <= 3);
        issue(2'b11, 0, 1'b0);
        wait_done(t);
        chk("R10", "zero-length read latency", t, 0, t <= 3);
        repeat (2) @(negedge clk);
        chk("R10", "no bus activity", nfall - fb, 0, nfall == fb);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule